// File: doc/BRIEF.md
# Digital PI Loop Filter with Serial DAC Write

This block closes a mixed digital/analog phase-locked loop. A phase detector delivers signed phase-error samples with a valid strobe. The block subtracts a programmable phase setpoint from each sample. It then runs a proportional-integral filter whose result is a tuning code for an external DAC, and that DAC sets the control voltage of a crystal oscillator. The loop therefore holds a chosen phase offset between the reference and the cleaned clock. It does not drive that offset to zero. No derivative term is used, because the loop only has to settle on a constant frequency.

Both gains are powers of two, applied as arithmetic right shifts, so the datapath has no multiplier. Each update appears as a parallel code with a one-cycle strobe. When the serial port is free, the same code also goes out as a 16-bit serial write. A lock flag reports when the corrected error has stayed inside a programmable window for a programmable number of consecutive samples.

Top module: `pi_loop_top`

## Requirements
- R1: While reset is active, and on the clock after `enable` is seen low, `dacCode` holds mid-scale (only the MSB set, 0x8000 for 16 bits), the integrator is cleared, `locked` is low and `dacStrobe` stays low.
- R2: The error used by the filter is `e = phaseErr - setpoint`, with both inputs treated as two's-complement signed values.
- R3: On each sample (`phaseValid` high while `enable` is high), the integrator becomes `I + (e >>> kiShift)`, clamped to the signed range -2^(DAC_W-1) .. 2^(DAC_W-1)-1.
- R4: On the same sample, the new code is `2^(DAC_W-1) + (e >>> kpShift) + I_new`, clamped to 0 .. 2^DAC_W-1. Both shifts are arithmetic and round toward minus infinity.
- R5: The new code appears on `dacCode`, together with a one-cycle `dacStrobe` pulse, in the cycle after the sample. No strobe occurs without a sample.
- R6: A `phaseValid` pulse while `enable` is low has no effect: no strobe, no serial frame, and `dacCode` stays at mid-scale.
- R7: A sample with |e| < `lockThresh` increments a saturating run count. `locked` rises with the sample at which the run reaches `lockCount`. A `lockCount` of 0 behaves as 1.
- R8: The first sample with |e| >= `lockThresh` clears the run count and lowers `locked`, with the update that follows that sample.
- R9: An update that finds the serial port idle starts a frame on the same clock edge that updates `dacCode`. `spiCsN` goes low and the DAC_W code bits follow, MSB first. `spiMosi` changes only while `spiSclk` is low, and `spiSclk` idles low. Each half SCLK period lasts SPI_HALF clocks.
- R10: `spiBusy` is high exactly while `spiCsN` is low, for 2*SPI_HALF*DAC_W clocks per frame (64 with the defaults).
- R11: An update that arrives while a frame is in progress still changes `dacCode` and pulses `dacStrobe`, but starts no frame. The frame in progress completes with its original code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Loop run enable; when low, the loop is cleared and parked |
| phaseErr | input | ERR_W | Signed phase-error sample |
| phaseValid | input | 1 | Qualifies `phaseErr` for one cycle |
| setpoint | input | ERR_W | Signed phase offset to regulate to |
| kpShift | input | SHIFT_W | Right-shift amount of the proportional term |
| kiShift | input | SHIFT_W | Right-shift amount of the integral step |
| lockThresh | input | ERR_W | Unsigned error window for lock |
| lockCount | input | LOCK_W | Consecutive in-window samples needed for lock |
| dacCode | output | DAC_W | Parallel DAC tuning code |
| dacStrobe | output | 1 | One-cycle pulse on each new code |
| locked | output | 1 | Lock indication |
| spiSclk | output | 1 | Serial clock to the DAC |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data, MSB first |
| spiBusy | output | 1 | High while a frame is in progress |

## Verification
The assertions assume that `phaseValid` is a single-cycle strobe. They also assume that the gain, setpoint and lock settings stay constant across a sample, so that any change to `dacCode` or `locked` can be traced back to a qualified sample of the previous cycle. The stimulus changes register inputs only between samples, and only while the serial port is idle. Samples are normally spaced wider than a full frame. The single exception is a deliberate pair of close samples that exercises the busy-skip behaviour.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic clearLoop;   // park the loop: zero integrator, mid-scale code
    logic updateLoop;  // accept the current phase sample
    logic loadShift;   // capture the new code into the serial shifter
    logic shiftOut;    // advance the serial shifter by one bit
  } loopStrobes_t;

endpackage

// File: rtl/pi_loop_datapath.sv
module pi_loop_datapath
  import pi_loop_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int DAC_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  loopStrobes_t       strobes,
  input  logic [ERR_W-1:0]   phaseErr,
  input  logic [ERR_W-1:0]   setpoint,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  input  logic [ERR_W-1:0]   lockThresh,
  output logic [DAC_W-1:0]   dacCode,
  output logic               dacStrobe,
  output logic               errSmall,
  output logic               spiMosi
);

  // The sum width covers the widest operand plus two bits of headroom
  localparam int WIDE_W = (ERR_W + 1 > DAC_W) ? ERR_W + 1 : DAC_W;
  localparam int SUM_W  = WIDE_W + 2;
  localparam int INT_HI_I = (1 << (DAC_W - 1)) - 1;
  localparam int CODE_HI_I = (1 << DAC_W) - 1;
  localparam logic signed [SUM_W-1:0] INT_HI  = SUM_W'(INT_HI_I);
  localparam logic signed [SUM_W-1:0] INT_LO  = SUM_W'(-INT_HI_I - 1);
  localparam logic signed [SUM_W-1:0] MID_S   = SUM_W'(INT_HI_I + 1);
  localparam logic signed [SUM_W-1:0] CODE_LO = '0;
  localparam logic signed [SUM_W-1:0] CODE_HI = SUM_W'(CODE_HI_I);
  localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};

  function automatic logic signed [SUM_W-1:0] clampS(
    input logic signed [SUM_W-1:0] v,
    input logic signed [SUM_W-1:0] lo,
    input logic signed [SUM_W-1:0] hi
  );
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  logic signed [DAC_W-1:0] integ;
  logic [DAC_W-1:0]        shReg;

  logic signed [ERR_W:0]   err;
  logic [ERR_W:0]          errMag;
  logic signed [ERR_W:0]   pTerm;
  logic signed [ERR_W:0]   iStep;
  logic signed [SUM_W-1:0] pExt;
  logic signed [SUM_W-1:0] iExt;
  logic signed [SUM_W-1:0] integExt;
  logic signed [SUM_W-1:0] integNext;
  logic signed [SUM_W-1:0] codeNext;

  // Error relative to the setpoint, with one extra bit so the difference cannot wrap
  always_comb begin
    err    = $signed({phaseErr[ERR_W-1], phaseErr}) - $signed({setpoint[ERR_W-1], setpoint});
    errMag = err[ERR_W] ? unsigned'(-err) : unsigned'(err);
    errSmall = errMag < {1'b0, lockThresh};
  end

  // Shift-based gains and saturating accumulation
  always_comb begin
    pTerm     = err >>> kpShift;
    iStep     = err >>> kiShift;
    pExt      = {{(SUM_W-ERR_W-1){pTerm[ERR_W]}}, pTerm};
    iExt      = {{(SUM_W-ERR_W-1){iStep[ERR_W]}}, iStep};
    integExt  = {{(SUM_W-DAC_W){integ[DAC_W-1]}}, integ};
    integNext = clampS(integExt + iExt, INT_LO, INT_HI);
    codeNext  = clampS(MID_S + pExt + integNext, CODE_LO, CODE_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integ     <= '0;
      dacCode   <= MID_CODE;
      dacStrobe <= 1'b0;
    end else begin
      dacStrobe <= strobes.updateLoop;
      if (strobes.clearLoop) begin
        integ   <= '0;
        dacCode <= MID_CODE;
      end else if (strobes.updateLoop) begin
        integ   <= $signed(integNext[DAC_W-1:0]);
        dacCode <= codeNext[DAC_W-1:0];
      end
    end
  end

  // Serial shifter: loads the fresh code and moves it out MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.loadShift) begin
      shReg <= codeNext[DAC_W-1:0];
    end else if (strobes.shiftOut) begin
      shReg <= {shReg[DAC_W-2:0], 1'b0};
    end
  end

  assign spiMosi = shReg[DAC_W-1];

endmodule

// File: rtl/pi_loop_ctrl.sv
module pi_loop_ctrl
  import pi_loop_pkg::*;
#(
  parameter int DAC_W    = 16,
  parameter int LOCK_W   = 8,
  parameter int SPI_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              phaseValid,
  input  logic              errSmall,
  input  logic [LOCK_W-1:0] lockCount,
  output loopStrobes_t      strobes,
  output logic              locked,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiBusy
);

  localparam int HALF_W = (SPI_HALF > 1) ? $clog2(SPI_HALF) : 1;
  localparam int BIT_W  = (DAC_W > 1) ? $clog2(DAC_W) : 1;
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SPI_HALF - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DAC_W - 1);
  localparam logic [LOCK_W-1:0] RUN_MAX   = '1;

  typedef enum logic {SPI_IDLE, SPI_XFER} spiState_t;

  spiState_t         spiState;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [LOCK_W-1:0] runLen;
  logic [LOCK_W-1:0] runInc;
  logic              halfDone;
  logic              lastBit;

  assign halfDone = (halfCnt == HALF_LAST);
  assign lastBit  = (bitCnt == BIT_LAST);
  assign runInc   = (runLen == RUN_MAX) ? runLen : runLen + 1'b1;

  always_comb begin
    strobes.clearLoop  = !enable;
    strobes.updateLoop = enable && phaseValid;
    strobes.loadShift  = enable && phaseValid && (spiState == SPI_IDLE);
    strobes.shiftOut   = (spiState == SPI_XFER) && halfDone && spiSclk && !lastBit;
  end

  // Lock qualification over consecutive in-window samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
      locked <= 1'b0;
    end else if (strobes.clearLoop) begin
      runLen <= '0;
      locked <= 1'b0;
    end else if (strobes.updateLoop) begin
      if (errSmall) begin
        runLen <= runInc;
        locked <= (runInc >= lockCount);
      end else begin
        runLen <= '0;
        locked <= 1'b0;
      end
    end
  end

  // Serial write sequencer, mode 0, one frame per accepted update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiState <= SPI_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      spiSclk  <= 1'b0;
      spiCsN   <= 1'b1;
    end else begin
      case (spiState)
        SPI_IDLE: begin
          if (strobes.loadShift) begin
            spiState <= SPI_XFER;
            spiCsN   <= 1'b0;
            halfCnt  <= '0;
            bitCnt   <= '0;
            spiSclk  <= 1'b0;
          end
        end
        SPI_XFER: begin
          if (halfDone) begin
            halfCnt <= '0;
            if (spiSclk) begin
              spiSclk <= 1'b0;
              if (lastBit) begin
                spiState <= SPI_IDLE;
                spiCsN   <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end else begin
              spiSclk <= 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: spiState <= SPI_IDLE;
      endcase
    end
  end

  assign spiBusy = (spiState == SPI_XFER);

endmodule

// File: rtl/pi_loop_top.sv
module pi_loop_top
  import pi_loop_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int DAC_W    = 16,
  parameter int SHIFT_W  = 4,
  parameter int LOCK_W   = 8,
  parameter int SPI_HALF = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [ERR_W-1:0]   phaseErr,
  input  logic               phaseValid,
  input  logic [ERR_W-1:0]   setpoint,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  input  logic [ERR_W-1:0]   lockThresh,
  input  logic [LOCK_W-1:0]  lockCount,
  output logic [DAC_W-1:0]   dacCode,
  output logic               dacStrobe,
  output logic               locked,
  output logic               spiSclk,
  output logic               spiCsN,
  output logic               spiMosi,
  output logic               spiBusy
);

  loopStrobes_t strobes;
  logic         errSmall;

  pi_loop_ctrl #(
    .DAC_W(DAC_W), .LOCK_W(LOCK_W), .SPI_HALF(SPI_HALF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .phaseValid(phaseValid),
    .errSmall(errSmall), .lockCount(lockCount), .strobes(strobes),
    .locked(locked), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiBusy(spiBusy)
  );

  pi_loop_datapath #(
    .ERR_W(ERR_W), .DAC_W(DAC_W), .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .phaseErr(phaseErr),
    .setpoint(setpoint), .kpShift(kpShift), .kiShift(kiShift),
    .lockThresh(lockThresh), .dacCode(dacCode), .dacStrobe(dacStrobe),
    .errSmall(errSmall), .spiMosi(spiMosi)
  );

endmodule

// File: rtl/pi_loop_checker.sv
module pi_loop_checker #(
  parameter int DAC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             phaseValid,
  input logic [DAC_W-1:0] dacCode,
  input logic             dacStrobe,
  input logic             locked,
  input logic             spiSclk,
  input logic             spiCsN,
  input logic             spiMosi,
  input logic             spiBusy
);

  localparam logic [DAC_W-1:0] PARK_CODE = {1'b1, {(DAC_W-1){1'b0}}};

  a_r1_park: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (dacCode == PARK_CODE && !locked && !dacStrobe))
    else $error("R1 loop not parked after disable");

  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    dacStrobe |-> $past(enable && phaseValid))
    else $error("R5 strobe without qualified sample");

  a_r7_lock_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(enable && phaseValid))
    else $error("R7 lock rose without a sample");

  a_r8_lock_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(!enable || phaseValid))
    else $error("R8 lock fell without a sample or disable");

  a_r9_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk)
    else $error("R9 sclk active outside a frame");

  a_r9_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi))
    else $error("R9 mosi moved while sclk high");

  a_r10_busy_cs: assert property (@(posedge clk) disable iff (!rstN)
    spiBusy == !spiCsN)
    else $error("R10 busy and chip select disagree");

endmodule

bind pi_loop_top pi_loop_checker #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .phaseValid(phaseValid),
  .dacCode(dacCode), .dacStrobe(dacStrobe), .locked(locked),
  .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiBusy(spiBusy)
);

// File: tb/sim_pi_loop_top.sv
module sim_pi_loop_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] phaseErr = '0;
  logic        phaseValid = 1'b0;
  logic [15:0] setpoint = '0;
  logic [3:0]  kpShift = '0;
  logic [3:0]  kiShift = '0;
  logic [15:0] lockThresh = '0;
  logic [7:0]  lockCount = '0;
  logic [15:0] dacCode;
  logic        dacStrobe, locked, spiSclk, spiCsN, spiMosi, spiBusy;

  pi_loop_top u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .phaseErr(phaseErr),
    .phaseValid(phaseValid), .setpoint(setpoint), .kpShift(kpShift),
    .kiShift(kiShift), .lockThresh(lockThresh), .lockCount(lockCount),
    .dacCode(dacCode), .dacStrobe(dacStrobe), .locked(locked),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiBusy(spiBusy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model state
  int mInteg = 0;
  int mRun = 0;
  int spS = 0;

  // Scoreboard queues
  int    codeQ[$];
  bit    lockQ[$];
  string tagQ[$];
  int    spiQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Driver: predict, push expectations, then apply one sample
  task automatic sendSample(input int pe, input int gap, input bit expectSpi, input string tag);
    int e, p, inc, code;
    bit lk;
    e = pe - spS;
    p = e >>> kpShift;
    inc = e >>> kiShift;
    mInteg = mInteg + inc;
    if (mInteg > 32767) mInteg = 32767;
    if (mInteg < -32768) mInteg = -32768;
    code = 32768 + p + mInteg;
    if (code > 65535) code = 65535;
    if (code < 0) code = 0;
    if ((e < 0 ? -e : e) < int'(lockThresh)) begin
      mRun = (mRun < 255) ? mRun + 1 : 255;
      lk = (mRun >= int'(lockCount));
    end else begin
      mRun = 0;
      lk = 0;
    end
    codeQ.push_back(code);
    lockQ.push_back(lk);
    tagQ.push_back(tag);
    if (expectSpi) spiQ.push_back(code);
    phaseErr = pe[15:0];
    phaseValid = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: parallel code and lock flag on every strobe
  always @(negedge clk) begin
    if (rstN && dacStrobe) begin
      if (codeQ.size() == 0) begin
        check(0, "R5/R6 unexpected strobe", int'(dacCode), -1);
      end else begin
        int expCode;
        bit expLk;
        string t;
        expCode = codeQ.pop_front();
        expLk = lockQ.pop_front();
        t = tagQ.pop_front();
        check(int'(dacCode) == expCode, t, int'(dacCode), expCode);
        check(locked == expLk, {t, " R7/R8 lock"}, int'(locked), int'(expLk));
      end
    end
  end

  // Monitor: serial frames
  int spiWord = 0;
  int spiBits = 0;
  always @(negedge spiCsN) begin
    spiWord = 0;
    spiBits = 0;
  end
  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      spiWord = ((spiWord << 1) | int'(spiMosi)) & 16'hFFFF;
      spiBits++;
    end
  end
  always @(posedge spiCsN) begin
    if (rstN) begin
      check(spiBits == 16, "R9 frame bit count", spiBits, 16);
      if (spiQ.size() == 0) begin
        check(0, "R11 unexpected frame", spiWord, -1);
      end else begin
        int expW;
        expW = spiQ.pop_front();
        check(spiWord == expW, "R9/R11 frame word", spiWord, expW);
      end
    end
  end

  // Monitor: busy duration
  int busyLen = 0;
  always @(negedge clk) begin
    if (spiBusy) begin
      busyLen++;
    end else if (busyLen != 0) begin
      check(busyLen == 64, "R10 busy length", busyLen, 64);
      busyLen = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dacCode == 16'h8000, "R1 reset code", int'(dacCode), 32768);
    check(locked == 1'b0, "R1 reset lock", int'(locked), 0);
    check(spiCsN == 1'b1 && spiBusy == 1'b0, "R10 idle port", int'(spiBusy), 0);
    check(spiSclk == 1'b0, "R9 sclk idle", int'(spiSclk), 0);

    // R6: sample while disabled
    kpShift = 4'd2; kiShift = 4'd4; lockThresh = 16'd100; lockCount = 8'd3;
    phaseErr = 16'd5000; phaseValid = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0;
    repeat (4) @(negedge clk);
    check(dacCode == 16'h8000, "R6 disabled sample code", int'(dacCode), 32768);
    check(spiCsN == 1'b1, "R6 disabled sample no frame", int'(spiCsN), 1);

    // R3 R4 R7 R8: basic tracking and lock
    enable = 1'b1;
    @(negedge clk);
    sendSample(1000, 80, 1, "R3/R4 pos error");
    sendSample(-500, 80, 1, "R3/R4 neg error");
    sendSample(40, 80, 1, "R7 good 1");
    sendSample(30, 80, 1, "R7 good 2");
    sendSample(20, 80, 1, "R7 good 3 locks");
    sendSample(15, 80, 1, "R7 stays locked");
    sendSample(500, 80, 1, "R8 drop");
    sendSample(-10, 80, 1, "R8 run restarts");

    // R2: setpoint offset
    setpoint = 16'd300; spS = 300;
    sendSample(300, 80, 1, "R2 zero error at setpoint");
    sendSample(310, 80, 1, "R2 small offset");
    setpoint = 16'hFF38; spS = -200;
    sendSample(-150, 80, 1, "R2 negative setpoint");

    // R3 R4: saturation both ways
    kpShift = 4'd0; kiShift = 4'd0;
    setpoint = 16'h8000; spS = -32768;
    sendSample(32767, 80, 1, "R4 clamp high 1");
    sendSample(32767, 80, 1, "R3 integ clamp high");
    setpoint = 16'h7FFF; spS = 32767;
    sendSample(-32768, 80, 1, "R4 clamp low 1");
    sendSample(-32768, 80, 1, "R3 integ descend");
    sendSample(-32768, 80, 1, "R3 integ clamp low");

    // R11: update during a frame
    kpShift = 4'd3; kiShift = 4'd6; setpoint = 16'd0; spS = 0;
    sendSample(200, 5, 1, "R11 first of pair");
    sendSample(-300, 80, 0, "R11 skipped for serial");
    sendSample(120, 80, 1, "R11 port free again");

    // R1: disable parks and clears
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(dacCode == 16'h8000, "R1 disable park", int'(dacCode), 32768);
    check(locked == 1'b0, "R1 disable unlock", int'(locked), 0);
    mInteg = 0; mRun = 0;
    enable = 1'b1;
    @(negedge clk);
    sendSample(640, 80, 1, "R1 integ restarts from zero");

    // R7: lockCount of 0 locks on the first good sample
    lockCount = 8'd0;
    sendSample(5, 80, 1, "R7 zero count locks at once");

    repeat (20) @(negedge clk);
    check(codeQ.size() == 0, "R5 all updates seen", codeQ.size(), 0);
    check(spiQ.size() == 0, "R9 all frames seen", spiQ.size(), 0);
    finishRun();
  end

endmodule